// File: doc/BRIEF.md
# Reset Classifier and Boot Sequencer

This block decides how a chip comes out of reset. While the boot reset is held low, it samples a pair of boot-mode pins. It also collects pending reset causes in sticky flags. On the first clock edge with the boot reset high, it sorts those flags into one class (cold, warm or hot) and fixes the boot mode. It then runs the startup steps strictly one at a time. Each step is started by a one-cycle strobe and finished by a shared done/error handshake.

The memory self-test, RAM clearing, trim loading and PLL switching are done by other logic. This block only starts them, waits for them and reacts to their answers. A counter of consecutive watchdog-caused resets survives boot resets and sends the device to sleep once the limit is reached. The final state shows whether the user/loader image, the debug path or an error halt was reached.

Top module: `boot_sequencer`

## Requirements
- R1: The pins are sampled on every clock while `boot_rst_n` is low, and are held while it is high. When the boot starts, pin value 2'b00 or 2'b01 selects user/loader mode (`boot_mode`=1), and 2'b11 selects debug mode (`boot_mode`=2). The reserved value 2'b10 goes straight to halt (`boot_mode`=3), giving one `wdt_en` pulse and no step strobes.
- R2: The bits of `cause_set` are mapped to flags as follows. Bit 0 is power-on, bit 1 is reset pin, bit 2 is watchdog and bit 3 is system failure; these four are cold. Bit 4 is sleep exit and bit 5 is stop exit; these are warm. Bit 6 is software and bit 7 is lock-up; these are hot.
- R3: `reset_class` is 0 for cold, 1 for warm and 2 for hot. Cold outranks warm, which outranks hot. When no flag is pending, the class is cold.
- R4: The flags are sticky and only `cause_clr` clears them. Power-on reset (`por_n`) leaves only the power-on flag set. A stale flag therefore still takes part in the next classification.
- R5: `mbist_go` is issued for a cold boot, or for any class when `mbist_force` is high at the start of the boot.
- R6: `ram_clr_go` is issued for cold and warm boots only.
- R7: A hot boot issues neither `trim_go` nor `pll_go`.
- R8: Steps run in a fixed order: `wdt_dis` (debug only), `mbist_go`, `ram_clr_go`, `trim_go`, `pll_go`. Only one strobe is high at any time, and each lasts one cycle. A step ends only when `step_done` or `step_err` is seen in a cycle after its strobe. Before the boot starts, no strobe is issued and `boot_mode` is 0.
- R9: `step_err` during a step goes to halt (`boot_mode`=3). Halt gives one `wdt_en` pulse, issues no further strobes and lasts until the next boot reset.
- R10: If `step_done` does not arrive within PLL_WAIT cycles after `pll_go`, `clk_fallback` is set and the boot completes normally. `clk_fallback` is cleared at the start of each boot.
- R11: A successful user/loader boot gives one `wdt_en` pulse and sets `boot_mode` to 1. A successful debug boot sets `boot_mode` to 2 without any `wdt_en`.
- R12: At the start of each boot, a pending watchdog flag increments the consecutive-watchdog count, and any other reset clears it. A successful boot also clears it. A boot that makes the count reach WDT_LIMIT (default 5) raises `sleep_req` instead, with no strobes and `boot_mode` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| boot_rst_n | input | 1 | Boot reset, synchronous, active low; rising edge starts a boot |
| boot_pins | input | 2 | Boot-mode pins |
| cause_set | input | 8 | Reset cause pulses that set the sticky flags |
| cause_clr | input | 1 | Clears all reset cause flags |
| mbist_force | input | 1 | Forces the RAM self-test for every class |
| step_done | input | 1 | Current step finished |
| step_err | input | 1 | Current step failed |
| mbist_go | output | 1 | Start RAM self-test |
| ram_clr_go | output | 1 | Start RAM clear |
| trim_go | output | 1 | Start analog trim load |
| pll_go | output | 1 | Start clock switch to PLL |
| wdt_dis | output | 1 | Disable watchdog pulse |
| wdt_en | output | 1 | Enable watchdog pulse |
| clk_fallback | output | 1 | PLL lock timed out; divided oscillator in use |
| boot_mode | output | 2 | 0 busy, 1 user/loader, 2 debug, 3 halt |
| reset_class | output | 2 | 0 cold, 1 warm, 2 hot |
| sleep_req | output | 1 | Watchdog reset limit reached |

## Verification
Some rules are checked by the assertions on every clock. At most one strobe is high at a time, and the test and clear strobes only appear for the classes that allow them. Hot boots never trim or switch the clock. The pins stay frozen after release, the flags stay sticky and the watchdog count stays within its limit. A waiting step never moves without an answer, halt lasts until the next boot reset, and a successful debug boot never enables the watchdog. Other behaviour can only be shown by the bench scenarios. These include the order of the strobes for each class and mode, which cause wins when several are pending, and a stale flag misclassifying a later reset. They also include the PLL timeout fallback and the run of watchdog resets that ends in sleep.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

    localparam int NUM_CAUSES = 8;

    localparam int CAUSE_POR     = 0;
    localparam int CAUSE_PIN     = 1;
    localparam int CAUSE_WDT     = 2;
    localparam int CAUSE_SYSFAIL = 3;
    localparam int CAUSE_SLEEPX  = 4;
    localparam int CAUSE_STOPX   = 5;
    localparam int CAUSE_SW      = 6;
    localparam int CAUSE_LOCKUP  = 7;

    localparam logic [NUM_CAUSES-1:0] COLD_MASK = 8'b0000_1111;
    localparam logic [NUM_CAUSES-1:0] WARM_MASK = 8'b0011_0000;
    localparam logic [NUM_CAUSES-1:0] HOT_MASK  = 8'b1100_0000;

    typedef enum logic [1:0] {
        CLS_COLD = 2'd0,
        CLS_WARM = 2'd1,
        CLS_HOT  = 2'd2
    } rst_class_e;

    localparam logic [1:0] MODE_BUSY  = 2'd0;
    localparam logic [1:0] MODE_USER  = 2'd1;
    localparam logic [1:0] MODE_DEBUG = 2'd2;
    localparam logic [1:0] MODE_HALT  = 2'd3;

    localparam logic [1:0] PINS_DEBUG    = 2'b11;
    localparam logic [1:0] PINS_RESERVED = 2'b10;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_WDT_OFF = 4'd1,
        ST_MBIST   = 4'd2,
        ST_CLEAR   = 4'd3,
        ST_TRIM    = 4'd4,
        ST_PLL     = 4'd5,
        ST_DONE    = 4'd6,
        ST_HALT    = 4'd7,
        ST_SLEEP   = 4'd8
    } boot_state_e;

endpackage

// File: rtl/rst_cause_tracker.sv
`timescale 1ns/1ps
module rst_cause_tracker
    import boot_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  por_n,
    input  logic [NUM_CAUSES-1:0] cause_set,
    input  logic                  cause_clr,
    output rst_class_e            cls_o,
    output logic                  wdt_pending_o
);

    typedef struct packed {
        logic [NUM_CAUSES-1:0] flags;
    } trk_t;

    trk_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cause_clr) begin
            r_d.flags = '0;
        end
        r_d.flags = r_d.flags | cause_set;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.flags <= NUM_CAUSES'(1) << CAUSE_POR;
        end else begin
            r_q <= r_d;
        end
    end

    logic [2:0] grp_hit;

    always_comb begin
        grp_hit[0] = |(r_q.flags & COLD_MASK);
        grp_hit[1] = |(r_q.flags & WARM_MASK);
        grp_hit[2] = |(r_q.flags & HOT_MASK);
        if (grp_hit[0]) begin
            cls_o = CLS_COLD;
        end else if (grp_hit[1]) begin
            cls_o = CLS_WARM;
        end else if (grp_hit[2]) begin
            cls_o = CLS_HOT;
        end else begin
            cls_o = CLS_COLD;
        end
    end

    assign wdt_pending_o = r_q.flags[CAUSE_WDT];

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        !cause_clr |=> ((r_q.flags & $past(r_q.flags)) == $past(r_q.flags))); // R4

endmodule

// File: rtl/wdt_streak_counter.sv
`timescale 1ns/1ps
module wdt_streak_counter #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic por_n,
    input  logic eval_i,
    input  logic wdt_i,
    input  logic success_i,
    output logic sleep_o
);

    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } stk_t;

    stk_t r_d, r_q;

    assign sleep_o = eval_i && wdt_i && (r_q.cnt >= CW'(LIMIT - 1));

    always_comb begin
        r_d = r_q;
        if (eval_i) begin
            if (wdt_i) begin
                if (r_q.cnt != CW'(LIMIT)) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end else begin
                r_d.cnt = '0;
            end
        end else if (success_i) begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_STREAK_CAP: assert property (@(posedge clk) disable iff (!por_n)
        r_q.cnt <= CW'(LIMIT)); // R12
    AST_SLEEP_AT_LIMIT: assert property (@(posedge clk) disable iff (!por_n)
        sleep_o |=> (r_q.cnt == CW'(LIMIT))); // R12

endmodule

// File: rtl/boot_step_fsm.sv
`timescale 1ns/1ps
module boot_step_fsm
    import boot_seq_pkg::*;
#(
    parameter int PLL_WAIT = 100000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       boot_rst_n,
    input  logic [1:0] boot_pins,
    input  logic       mbist_force,
    input  rst_class_e cls_i,
    input  logic       sleep_hit_i,
    input  logic       step_done,
    input  logic       step_err,
    output logic       release_o,
    output logic       finish_o,
    output logic       mbist_go_o,
    output logic       clr_go_o,
    output logic       trim_go_o,
    output logic       pll_go_o,
    output logic       wdt_dis_o,
    output logic       wdt_en_o,
    output logic       fallback_o,
    output logic [1:0] mode_o,
    output rst_class_e cls_o
);

    localparam int TW = (PLL_WAIT > 2) ? $clog2(PLL_WAIT) : 1;

    typedef struct packed {
        boot_state_e   state;
        logic          issued;
        rst_class_e    cls;
        logic          dbg;
        logic          force_b;
        logic [1:0]    pins;
        logic [TW-1:0] tmr;
        logic          fallback;
    } fsm_t;

    fsm_t r_d, r_q;

    function automatic boot_state_e after_step(boot_state_e cur, rst_class_e c, logic f);
        logic do_mb, do_cl, do_an;
        do_mb = (c == CLS_COLD) || f;
        do_cl = (c != CLS_HOT);
        do_an = (c != CLS_HOT);
        if ((cur == ST_WDT_OFF) && do_mb) begin
            return ST_MBIST;
        end else if ((cur inside {ST_WDT_OFF, ST_MBIST}) && do_cl) begin
            return ST_CLEAR;
        end else if ((cur inside {ST_WDT_OFF, ST_MBIST, ST_CLEAR}) && do_an) begin
            return ST_TRIM;
        end else if ((cur inside {ST_WDT_OFF, ST_MBIST, ST_CLEAR, ST_TRIM}) && do_an) begin
            return ST_PLL;
        end
        return ST_DONE;
    endfunction

    always_comb begin
        r_d        = r_q;
        release_o  = 1'b0;
        finish_o   = 1'b0;
        mbist_go_o = 1'b0;
        clr_go_o   = 1'b0;
        trim_go_o  = 1'b0;
        pll_go_o   = 1'b0;
        wdt_dis_o  = 1'b0;
        wdt_en_o   = 1'b0;
        if (!boot_rst_n) begin
            r_d.state  = ST_RESET;
            r_d.issued = 1'b0;
            r_d.pins   = boot_pins;
            r_d.tmr    = '0;
        end else begin
            case (r_q.state)
                ST_RESET: begin
                    release_o    = 1'b1;
                    r_d.cls      = cls_i;
                    r_d.force_b  = mbist_force;
                    r_d.fallback = 1'b0;
                    r_d.issued   = 1'b0;
                    r_d.tmr      = '0;
                    r_d.dbg      = (r_q.pins == PINS_DEBUG);
                    if (sleep_hit_i) begin
                        r_d.state = ST_SLEEP;
                    end else if (r_q.pins == PINS_RESERVED) begin
                        r_d.state = ST_HALT;
                    end else if (r_q.pins == PINS_DEBUG) begin
                        r_d.state = ST_WDT_OFF;
                    end else begin
                        r_d.state = after_step(ST_WDT_OFF, cls_i, mbist_force);
                    end
                end
                ST_WDT_OFF: begin
                    wdt_dis_o  = !r_q.issued;
                    r_d.issued = 1'b1;
                    if (r_q.issued) begin
                        r_d.issued = 1'b0;
                        r_d.state  = after_step(ST_WDT_OFF, r_q.cls, r_q.force_b);
                    end
                end
                ST_MBIST, ST_CLEAR, ST_TRIM: begin
                    mbist_go_o = (r_q.state == ST_MBIST) && !r_q.issued;
                    clr_go_o   = (r_q.state == ST_CLEAR) && !r_q.issued;
                    trim_go_o  = (r_q.state == ST_TRIM) && !r_q.issued;
                    r_d.issued = 1'b1;
                    if (r_q.issued) begin
                        if (step_err) begin
                            r_d.state  = ST_HALT;
                            r_d.issued = 1'b0;
                        end else if (step_done) begin
                            r_d.state  = after_step(r_q.state, r_q.cls, r_q.force_b);
                            r_d.issued = 1'b0;
                        end
                    end
                end
                ST_PLL: begin
                    pll_go_o   = !r_q.issued;
                    r_d.issued = 1'b1;
                    if (r_q.issued) begin
                        if (step_err) begin
                            r_d.state  = ST_HALT;
                            r_d.issued = 1'b0;
                        end else if (step_done) begin
                            r_d.state  = ST_DONE;
                            r_d.issued = 1'b0;
                        end else if (r_q.tmr == TW'(PLL_WAIT - 1)) begin
                            r_d.fallback = 1'b1;
                            r_d.state    = ST_DONE;
                            r_d.issued   = 1'b0;
                        end else begin
                            r_d.tmr = r_q.tmr + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    wdt_en_o   = !r_q.issued && !r_q.dbg;
                    finish_o   = !r_q.issued;
                    r_d.issued = 1'b1;
                end
                ST_HALT: begin
                    wdt_en_o   = !r_q.issued;
                    r_d.issued = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.state    <= ST_RESET;
            r_q.issued   <= 1'b0;
            r_q.cls      <= CLS_COLD;
            r_q.dbg      <= 1'b0;
            r_q.force_b  <= 1'b0;
            r_q.pins     <= '0;
            r_q.tmr      <= '0;
            r_q.fallback <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.state)
            ST_DONE: mode_o = r_q.dbg ? MODE_DEBUG : MODE_USER;
            ST_HALT: mode_o = MODE_HALT;
            default: mode_o = MODE_BUSY;
        endcase
    end

    assign cls_o      = r_q.cls;
    assign fallback_o = r_q.fallback;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({mbist_go_o, clr_go_o, trim_go_o, pll_go_o, wdt_dis_o, wdt_en_o})); // R8
    AST_HOT_NO_ANALOG: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.state != ST_RESET && r_q.cls == CLS_HOT) |-> (!trim_go_o && !pll_go_o)); // R7
    AST_MBIST_GATE: assert property (@(posedge clk) disable iff (!por_n)
        mbist_go_o |-> (r_q.cls == CLS_COLD || r_q.force_b)); // R5
    AST_CLEAR_GATE: assert property (@(posedge clk) disable iff (!por_n)
        clr_go_o |-> (r_q.cls != CLS_HOT)); // R6
    AST_STEP_WAITS: assert property (@(posedge clk) disable iff (!por_n)
        (boot_rst_n && r_q.state == ST_TRIM && r_q.issued && !step_done && !step_err)
        |=> (r_q.state == ST_TRIM)); // R8
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (boot_rst_n && r_q.state == ST_HALT) |=> (r_q.state == ST_HALT)); // R9
    AST_DEBUG_NO_WDT_EN: assert property (@(posedge clk) disable iff (!por_n)
        (r_q.state == ST_DONE && r_q.dbg) |-> !wdt_en_o); // R11
    AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        boot_rst_n |=> $stable(r_q.pins)); // R1

endmodule

// File: rtl/boot_sequencer.sv
`timescale 1ns/1ps
module boot_sequencer
    import boot_seq_pkg::*;
#(
    parameter int PLL_WAIT  = 100000,
    parameter int WDT_LIMIT = 5
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  boot_rst_n,
    input  logic [1:0]            boot_pins,
    input  logic [NUM_CAUSES-1:0] cause_set,
    input  logic                  cause_clr,
    input  logic                  mbist_force,
    input  logic                  step_done,
    input  logic                  step_err,
    output logic                  mbist_go,
    output logic                  ram_clr_go,
    output logic                  trim_go,
    output logic                  pll_go,
    output logic                  wdt_dis,
    output logic                  wdt_en,
    output logic                  clk_fallback,
    output logic [1:0]            boot_mode,
    output logic [1:0]            reset_class,
    output logic                  sleep_req
);

    rst_class_e cls_now;
    rst_class_e cls_held;
    logic       wdt_pending;
    logic       release_s;
    logic       finish_s;
    logic       sleep_hit;
    logic       in_sleep_q;

    rst_cause_tracker u_cause (
        .clk           (clk),
        .por_n         (por_n),
        .cause_set     (cause_set),
        .cause_clr     (cause_clr),
        .cls_o         (cls_now),
        .wdt_pending_o (wdt_pending)
    );

    wdt_streak_counter #(
        .LIMIT (WDT_LIMIT)
    ) u_streak (
        .clk       (clk),
        .por_n     (por_n),
        .eval_i    (release_s),
        .wdt_i     (wdt_pending),
        .success_i (finish_s),
        .sleep_o   (sleep_hit)
    );

    boot_step_fsm #(
        .PLL_WAIT (PLL_WAIT)
    ) u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .boot_rst_n  (boot_rst_n),
        .boot_pins   (boot_pins),
        .mbist_force (mbist_force),
        .cls_i       (cls_now),
        .sleep_hit_i (sleep_hit),
        .step_done   (step_done),
        .step_err    (step_err),
        .release_o   (release_s),
        .finish_o    (finish_s),
        .mbist_go_o  (mbist_go),
        .clr_go_o    (ram_clr_go),
        .trim_go_o   (trim_go),
        .pll_go_o    (pll_go),
        .wdt_dis_o   (wdt_dis),
        .wdt_en_o    (wdt_en),
        .fallback_o  (clk_fallback),
        .mode_o      (boot_mode),
        .cls_o       (cls_held)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            in_sleep_q <= 1'b0;
        end else if (!boot_rst_n) begin
            in_sleep_q <= 1'b0;
        end else if (release_s) begin
            in_sleep_q <= sleep_hit;
        end
    end

    assign sleep_req   = in_sleep_q;
    assign reset_class = cls_held;

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        sleep_req |-> !(mbist_go || ram_clr_go || trim_go || pll_go || wdt_dis || wdt_en)); // R12
    AST_SLEEP_NOT_MODE: assert property (@(posedge clk) disable iff (!por_n)
        sleep_req |-> (boot_mode == 2'd0)); // R12

endmodule

// File: tb/boot_sequencer_test.sv
`timescale 1ns/1ps
module boot_sequencer_test;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       boot_rst_n = 1'b0;
    logic [1:0] boot_pins = 2'b00;
    logic [7:0] cause_set = 8'h00;
    logic       cause_clr = 1'b0;
    logic       mbist_force = 1'b0;
    logic       step_done = 1'b0;
    logic       step_err = 1'b0;
    logic       mbist_go, ram_clr_go, trim_go, pll_go, wdt_dis, wdt_en;
    logic       clk_fallback, sleep_req;
    logic [1:0] boot_mode, reset_class;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    boot_sequencer #(
        .PLL_WAIT  (12),
        .WDT_LIMIT (5)
    ) uut (
        .clk          (clk),
        .por_n        (por_n),
        .boot_rst_n   (boot_rst_n),
        .boot_pins    (boot_pins),
        .cause_set    (cause_set),
        .cause_clr    (cause_clr),
        .mbist_force  (mbist_force),
        .step_done    (step_done),
        .step_err     (step_err),
        .mbist_go     (mbist_go),
        .ram_clr_go   (ram_clr_go),
        .trim_go      (trim_go),
        .pll_go       (pll_go),
        .wdt_dis      (wdt_dis),
        .wdt_en       (wdt_en),
        .clk_fallback (clk_fallback),
        .boot_mode    (boot_mode),
        .reset_class  (reset_class),
        .sleep_req    (sleep_req)
    );

    // strobe codes: 1 wdt_dis, 2 mbist, 3 clear, 4 trim, 5 pll, 6 wdt_en
    typedef struct packed {
        logic        clr;
        logic [7:0]  set;
        logic [1:0]  pins;
        logic        frc;
        logic [3:0]  err;
        logic        lock;
        logic [3:0]  lag;
        logic [31:0] seq;
        logic [1:0]  mode;
        logic [1:0]  cls;
        logic        fb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 2'b00, 1'b0, 4'd0, 1'b1, 4'd0, 32'h23456, 2'd1, 2'd0, 1'b0}, // R4 power-on flag, R1 R5 R6 R8 R11
        '{1'b1, 8'h40, 2'b00, 1'b0, 4'd0, 1'b1, 4'd0, 32'h6,     2'd1, 2'd2, 1'b0}, // R2 software -> hot, R7
        '{1'b1, 8'h10, 2'b00, 1'b0, 4'd0, 1'b1, 4'd0, 32'h3456,  2'd1, 2'd1, 1'b0}, // R2 sleep exit -> warm, R6
        '{1'b0, 8'h80, 2'b00, 1'b0, 4'd0, 1'b1, 4'd0, 32'h3456,  2'd1, 2'd1, 1'b0}, // R4 stale warm beats new lock-up
        '{1'b1, 8'ha0, 2'b01, 1'b0, 4'd0, 1'b1, 4'd0, 32'h3456,  2'd1, 2'd1, 1'b0}, // R3 warm over hot
        '{1'b1, 8'h42, 2'b00, 1'b0, 4'd0, 1'b1, 4'd6, 32'h23456, 2'd1, 2'd0, 1'b0}, // R3 cold over hot, R8 slow answers
        '{1'b1, 8'h08, 2'b11, 1'b0, 4'd0, 1'b1, 4'd0, 32'h12345, 2'd2, 2'd0, 1'b0}, // R1 debug, R11
        '{1'b1, 8'h80, 2'b01, 1'b1, 4'd0, 1'b1, 4'd0, 32'h26,    2'd1, 2'd2, 1'b0}, // R5 forced test on hot
        '{1'b1, 8'h20, 2'b00, 1'b1, 4'd0, 1'b1, 4'd0, 32'h23456, 2'd1, 2'd1, 1'b0}, // R5 forced test on warm
        '{1'b1, 8'h02, 2'b00, 1'b0, 4'd4, 1'b1, 4'd0, 32'h2346,  2'd3, 2'd0, 1'b0}, // R9 trim error
        '{1'b1, 8'h02, 2'b10, 1'b0, 4'd0, 1'b1, 4'd0, 32'h6,     2'd3, 2'd0, 1'b0}, // R1 reserved pins
        '{1'b1, 8'h40, 2'b11, 1'b0, 4'd0, 1'b1, 4'd0, 32'h1,     2'd2, 2'd2, 1'b0}, // R7 hot debug
        '{1'b1, 8'h02, 2'b00, 1'b0, 4'd0, 1'b0, 4'd0, 32'h23456, 2'd1, 2'd0, 1'b1}, // R10 no lock
        '{1'b1, 8'h00, 2'b00, 1'b0, 4'd0, 1'b1, 4'd0, 32'h23456, 2'd1, 2'd0, 1'b0}, // R3 nothing pending
        '{1'b1, 8'h02, 2'b11, 1'b0, 4'd2, 1'b1, 4'd0, 32'h126,   2'd3, 2'd0, 1'b0}  // R9 debug test error
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_boot(input logic clr, input logic [7:0] set, input logic [1:0] pins,
                            input logic frc, input logic [3:0] err, input logic lock,
                            input logic [3:0] lag, output logic [31:0] seq, output logic fin);
        logic [3:0] resp;
        int         wait_n;
        seq    = '0;
        fin    = 1'b0;
        resp   = '0;
        wait_n = 0;
        @(negedge clk);
        boot_rst_n  = 1'b0;
        cause_clr   = clr;
        boot_pins   = pins;
        mbist_force = frc;
        @(negedge clk);
        cause_clr = 1'b0;
        cause_set = set;
        @(negedge clk);
        cause_set = 8'h00;
        @(negedge clk);
        boot_rst_n = 1'b1;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            step_done = 1'b0;
            step_err  = 1'b0;
            if (resp != 0) begin
                if (wait_n > 0) begin
                    wait_n--;
                end else begin
                    if (resp == err) step_err = 1'b1;
                    else if (!(resp == 4'd5 && !lock)) step_done = 1'b1;
                    resp = '0;
                end
            end
            if (wdt_dis)    seq = {seq[27:0], 4'd1};
            if (mbist_go)   begin seq = {seq[27:0], 4'd2}; resp = 4'd2; wait_n = int'(lag); end
            if (ram_clr_go) begin seq = {seq[27:0], 4'd3}; resp = 4'd3; wait_n = int'(lag); end
            if (trim_go)    begin seq = {seq[27:0], 4'd4}; resp = 4'd4; wait_n = int'(lag); end
            if (pll_go)     begin seq = {seq[27:0], 4'd5}; resp = 4'd5; wait_n = int'(lag); end
            if (wdt_en)     seq = {seq[27:0], 4'd6};
            if (boot_mode != 2'd0 || sleep_req) begin
                fin = 1'b1;
                break;
            end
        end
        // watch a few more cycles for stray strobes after the final state
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            step_done = 1'b0;
            step_err  = 1'b0;
            if (mbist_go || ram_clr_go || trim_go || pll_go || wdt_dis || wdt_en)
                seq = {seq[27:0], 4'hf};
        end
    endtask

    task automatic wdt_round(input bit expect_sleep);
        logic [31:0] s;
        logic        f;
        run_boot(1'b1, 8'h04, 2'b00, 1'b0, 4'd2, 1'b1, 4'd0, s, f);
        if (expect_sleep) begin
            chk("R12 sleep at limit", {31'd0, sleep_req}, 32'd1);
            chk("R12 no strobes in sleep", s, 32'h0);
            chk("R12 mode busy in sleep", {30'd0, boot_mode}, 32'd0);
        end else begin
            chk("R12 below limit no sleep", {31'd0, sleep_req}, 32'd0);
            chk("R12 R9 halt sequence", s, 32'h26);
            chk("R2 watchdog is cold", {30'd0, reset_class}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic        f;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        // R8 idle before the boot starts
        chk("R8 reset mode busy", {30'd0, boot_mode}, 32'd0);
        chk("R8 reset no strobes",
            {26'd0, mbist_go, ram_clr_go, trim_go, pll_go, wdt_dis, wdt_en}, 32'd0);
        chk("R12 reset no sleep", {31'd0, sleep_req}, 32'd0);
        chk("R10 reset no fallback", {31'd0, clk_fallback}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_boot(VEC[i].clr, VEC[i].set, VEC[i].pins, VEC[i].frc, VEC[i].err,
                     VEC[i].lock, VEC[i].lag, s, f);
            chk($sformatf("R8 vec%0d finished", i), {31'd0, f}, 32'd1);
            chk($sformatf("R8 R5 R6 R7 vec%0d strobe order", i), s, VEC[i].seq);
            chk($sformatf("R1 R11 vec%0d mode", i), {30'd0, boot_mode}, {30'd0, VEC[i].mode});
            chk($sformatf("R3 vec%0d class", i), {30'd0, reset_class}, {30'd0, VEC[i].cls});
            chk($sformatf("R10 vec%0d fallback", i), {31'd0, clk_fallback}, {31'd0, VEC[i].fb});
            chk($sformatf("R12 vec%0d no sleep", i), {31'd0, sleep_req}, 32'd0);
        end

        // R12 watchdog streak: four halts, fifth goes to sleep
        for (int k = 0; k < 4; k++) wdt_round(1'b0);
        wdt_round(1'b1);
        wdt_round(1'b1);
        // a reset-pin boot clears the streak
        run_boot(1'b1, 8'h02, 2'b00, 1'b0, 4'd0, 1'b1, 4'd0, s, f);
        chk("R12 pin reset leaves sleep", {31'd0, sleep_req}, 32'd0);
        chk("R12 pin reset boots user", {30'd0, boot_mode}, 32'd1);
        for (int k = 0; k < 4; k++) wdt_round(1'b0);
        wdt_round(1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule